// File: doc/BRIEF.md
# I2C Combined-Transaction Master Sequencer

This block carries out one whole I2C master transaction for a single command. The command gives the direction, a 7-bit device address, 0 to 4 register-address bytes and a data length. The sequencer waits for the bus to go quiet and then opens the transfer with START and the device address. It sends the register bytes, turns a read around with a repeated START, moves the data bytes and closes with STOP. Each step is handed to a byte-level I2C engine through a one-cycle `eng_go` strobe. The engine answers with a completion strobe that carries the ACK/NACK and arbitration-loss flags.

Write data is pulled one byte per `wr_pop` strobe. Read data leaves on `rd_data` with a one-cycle `rd_valid` strobe. When the transaction ends, a single-cycle `done` pulse qualifies a 3-bit result code. A probe for a device is simply a one-byte read with no register bytes.

Top module: `i2cseq_top`

## Requirements
- R1: A command with a data length of zero, or with a register-address count above 4, ends with result 1 (generic failure). No engine operation is issued.
- R2: Before START, the sequencer waits while `bus_busy` is high. If the bus stays busy past the timeout limit, the result is 4 (timeout) and no engine operation is issued. If the bus clears in time, the transaction proceeds normally.
- R3: The first engine operation carries the device byte {dev, rw}. For a write, or for a read with register bytes, it is start-in-transmit (`eng_op`=0) with rw=0. For a read with no register bytes, it is start-in-receive (`eng_op`=1) with rw=1.
- R4: Register bytes are sent as transmit operations (`eng_op`=2). Exactly `cmd_alen` of them are sent, taken from the low `cmd_alen` bytes of `cmd_regaddr`, most significant byte first.
- R5: A read with register bytes sends a repeated start-in-receive (`eng_op`=1, byte {dev,1}) after the last register byte and before any data.
- R6: Read data bytes are receive operations (`eng_op`=3). `eng_last` is 1 only on the final byte. Each received byte appears on `rd_data` with a `rd_valid` strobe, in order. A NACK reported on a received byte is not an error, so a completed read gives result 0.
- R7: A NACK on any transmitted byte (device, register, repeated device or write data) gives result 2. All remaining byte phases are skipped.
- R8: If a byte's completion does not arrive within the timeout limit, the result is 4 and the remaining phases are skipped.
- R9: A completion flagged as arbitration loss gives result 3. The remaining phases are skipped.
- R10: Every transaction that issued a start issues exactly one STOP (`eng_op`=4) as its last engine operation. `done` pulses for one cycle, in the cycle after that STOP.
- R11: A command is accepted only while `cmd_ready` is high. A `cmd_valid` during a transaction has no effect.
- R12: A probe (read, no register bytes, length 1) returns 0 when the device byte is ACKed and 2 when it is NACKed.
- R13: A write sends exactly `cmd_len` data bytes as transmit operations. Each takes `wr_byte` in the cycle of its `wr_pop` strobe, in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | 7-bit device address |
| cmd_alen | input | ALEN_W | Number of register-address bytes |
| cmd_regaddr | input | 8*MAX_ALEN | Register address, low bytes used |
| cmd_len | input | LEN_W | Data byte count |
| wr_byte | input | 8 | Next write data byte |
| wr_pop | output | 1 | Current write byte consumed |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | `rd_data` valid strobe |
| bus_busy | input | 1 | Bus currently occupied |
| eng_go | output | 1 | Engine operation strobe |
| eng_op | output | 3 | Engine operation code (0..4) |
| eng_byte | output | 8 | Byte to transmit |
| eng_last | output | 1 | Receive: final byte, answer with NACK |
| eng_done | input | 1 | Engine byte completion strobe |
| eng_nack | input | 1 | Byte was NACKed |
| eng_lost | input | 1 | Arbitration lost on this byte |
| eng_rbyte | input | 8 | Received byte from engine |
| done | output | 1 | Transaction finished, result valid |
| result | output | 3 | 0 OK, 1 fail, 2 NACK, 3 lost, 4 timeout |

## Verification
Two functions can land in the same cycle: a byte completion arriving and the per-byte timeout expiring. A NACK or arbitration loss can also coincide with the final byte of a read, where a NACK is expected and must not become an error. The bench sweeps direction, register-byte count and data length, and checks each log. It also injects a NACK, an arbitration loss or a hang at every byte position of a write and a read. It then judges whether the engine operation log is truncated at exactly that byte, always followed by one STOP, and whether the result code matches.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        RES_OK   = 3'd0,
        RES_FAIL = 3'd1,
        RES_NACK = 3'd2,
        RES_LOST = 3'd3,
        RES_TOUT = 3'd4
    } res_e;

    typedef enum logic [2:0] {
        OP_START_TX = 3'd0,
        OP_START_RX = 3'd1,
        OP_TX       = 3'd2,
        OP_RX       = 3'd3,
        OP_STOP     = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BUSYWAIT,
        S_ISSUE,
        S_WAIT,
        S_STOP,
        S_FINISH
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_REDEV,
        PH_DATA
    } ph_e;

    function automatic logic [7:0] dev_byte(input logic [6:0] dev, input logic rnw);
        return {dev, rnw};
    endfunction

endpackage

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int LIMIT = 1000,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != TW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TW'(LIMIT));
endmodule

// File: rtl/i2cseq_regsel.sv
module i2cseq_regsel #(
    parameter int MAX_ALEN = 4,
    localparam int ALEN_W = $clog2(MAX_ALEN + 1)
) (
    input  logic [8*MAX_ALEN-1:0] regaddr,
    input  logic [ALEN_W-1:0]     alen,
    input  logic [ALEN_W-1:0]     idx,
    output logic [7:0]            sel_byte
);
    logic [7:0]        lane [MAX_ALEN];
    logic [ALEN_W-1:0] pick;

    for (genvar g = 0; g < MAX_ALEN; g++) begin : g_lane
        assign lane[g] = regaddr[g*8 +: 8];
    end

    assign pick = alen - idx - 1'b1;

    always_comb begin
        sel_byte = 8'h00;
        for (int i = 0; i < MAX_ALEN; i++) begin
            if (pick == ALEN_W'(i)) sel_byte = lane[i];
        end
    end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int MAX_ALEN   = 4,
    parameter int TMO_CYCLES = 1000,
    localparam int ALEN_W    = $clog2(MAX_ALEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_read,
    input  logic [6:0]            cmd_dev,
    input  logic [ALEN_W-1:0]     cmd_alen,
    input  logic [8*MAX_ALEN-1:0] cmd_regaddr,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic [7:0]            wr_byte,
    output logic                  wr_pop,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    input  logic                  bus_busy,
    output logic                  eng_go,
    output logic [2:0]            eng_op,
    output logic [7:0]            eng_byte,
    output logic                  eng_last,
    input  logic                  eng_done,
    input  logic                  eng_nack,
    input  logic                  eng_lost,
    input  logic [7:0]            eng_rbyte,
    output logic                  done,
    output logic [2:0]            result
);
    st_e                   st;
    ph_e                   ph;
    res_e                  res;
    logic                  req_rd;
    logic [6:0]            req_dev;
    logic [ALEN_W-1:0]     req_alen;
    logic [8*MAX_ALEN-1:0] req_raddr;
    logic [LEN_W-1:0]      req_len;
    logic [ALEN_W-1:0]     idx;
    logic [LEN_W-1:0]      dcnt;
    logic                  tmo;
    logic                  run_tmr;
    logic [7:0]            reg_byte;
    logic                  rx_only;
    logic                  last_data;
    logic                  last_reg;
    logic                  nack_is_err;

    assign run_tmr     = (st == S_BUSYWAIT) || (st == S_WAIT);
    assign rx_only     = req_rd && (req_alen == '0);
    assign last_data   = (dcnt == req_len - 1'b1);
    assign last_reg    = (idx == req_alen - 1'b1);
    assign nack_is_err = !((ph == PH_DATA) && req_rd);

    i2cseq_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (run_tmr),
        .expired (tmo)
    );

    i2cseq_regsel #(.MAX_ALEN(MAX_ALEN)) u_rsel (
        .regaddr  (req_raddr),
        .alen     (req_alen),
        .idx      (idx),
        .sel_byte (reg_byte)
    );

    // Operation presented to the byte engine
    always_comb begin
        eng_go   = 1'b0;
        eng_op   = OP_TX;
        eng_byte = 8'h00;
        eng_last = 1'b0;
        wr_pop   = 1'b0;
        if (st == S_ISSUE) begin
            eng_go = 1'b1;
            unique case (ph)
                PH_DEV: begin
                    eng_op   = rx_only ? OP_START_RX : OP_START_TX;
                    eng_byte = dev_byte(req_dev, rx_only);
                end
                PH_REG: begin
                    eng_op   = OP_TX;
                    eng_byte = reg_byte;
                end
                PH_REDEV: begin
                    eng_op   = OP_START_RX;
                    eng_byte = dev_byte(req_dev, 1'b1);
                end
                PH_DATA: begin
                    if (req_rd) begin
                        eng_op   = OP_RX;
                        eng_last = last_data;
                    end else begin
                        eng_op   = OP_TX;
                        eng_byte = wr_byte;
                        wr_pop   = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (st == S_STOP) begin
            eng_go = 1'b1;
            eng_op = OP_STOP;
        end
    end

    assign cmd_ready = (st == S_IDLE);
    assign done      = (st == S_FINISH);
    assign result    = res;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            ph        <= PH_DEV;
            res       <= RES_OK;
            req_rd    <= 1'b0;
            req_dev   <= '0;
            req_alen  <= '0;
            req_raddr <= '0;
            req_len   <= '0;
            idx       <= '0;
            dcnt      <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= 8'h00;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (cmd_valid) begin
                        req_rd    <= cmd_read;
                        req_dev   <= cmd_dev;
                        req_alen  <= cmd_alen;
                        req_raddr <= cmd_regaddr;
                        req_len   <= cmd_len;
                        idx       <= '0;
                        dcnt      <= '0;
                        ph        <= PH_DEV;
                        if (cmd_len == '0 || cmd_alen > ALEN_W'(MAX_ALEN)) begin
                            res <= RES_FAIL;
                            st  <= S_FINISH;
                        end else begin
                            res <= RES_OK;
                            st  <= S_BUSYWAIT;
                        end
                    end
                end
                S_BUSYWAIT: begin
                    if (!bus_busy) begin
                        st <= S_ISSUE;
                    end else if (tmo) begin
                        res <= RES_TOUT;
                        st  <= S_FINISH;
                    end
                end
                S_ISSUE: begin
                    st <= S_WAIT;
                end
                S_WAIT: begin
                    if (eng_done) begin
                        if (eng_lost) begin
                            res <= RES_LOST;
                            st  <= S_STOP;
                        end else if (eng_nack && nack_is_err) begin
                            res <= RES_NACK;
                            st  <= S_STOP;
                        end else begin
                            st <= S_ISSUE;
                            unique case (ph)
                                PH_DEV: begin
                                    ph <= (req_alen != '0) ? PH_REG : PH_DATA;
                                end
                                PH_REG: begin
                                    if (last_reg) begin
                                        ph <= req_rd ? PH_REDEV : PH_DATA;
                                    end else begin
                                        idx <= idx + 1'b1;
                                    end
                                end
                                PH_REDEV: begin
                                    ph <= PH_DATA;
                                end
                                PH_DATA: begin
                                    if (req_rd) begin
                                        rd_valid <= 1'b1;
                                        rd_data  <= eng_rbyte;
                                    end
                                    if (last_data) begin
                                        res <= RES_OK;
                                        st  <= S_STOP;
                                    end else begin
                                        dcnt <= dcnt + 1'b1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end else if (tmo) begin
                        res <= RES_TOUT;
                        st  <= S_STOP;
                    end
                end
                S_STOP: begin
                    st <= S_FINISH;
                end
                S_FINISH: begin
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       eng_go,
    input logic [2:0] eng_op,
    input logic       wr_pop,
    input logic       rd_valid,
    input logic       done,
    input logic [2:0] result
);
    logic seen_any;
    logic seen_stop;

    always_ff @(posedge clk) begin
        if (rst || (cmd_valid && cmd_ready)) begin
            seen_any  <= 1'b0;
            seen_stop <= 1'b0;
        end else begin
            if (eng_go) seen_any <= 1'b1;
            if (eng_go && eng_op == 3'd4) seen_stop <= 1'b1;
        end
    end

    AST_FAIL_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (done && result == 3'd1) |-> !seen_any); // R1
    AST_NACK_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (done && result == 3'd2) |-> seen_stop); // R7
    AST_LOST_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (done && result == 3'd3) |-> seen_stop); // R9
    AST_OK_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (done && result == 3'd0) |-> seen_stop); // R10
    AST_STOP_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (eng_go && eng_op == 3'd4) |=> done); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (eng_go || wr_pop || rd_valid) |-> !cmd_ready); // R11
    AST_POP_WITH_TX: assert property (@(posedge clk) disable iff (rst)
        wr_pop |-> (eng_go && eng_op == 3'd2)); // R13
endmodule

bind i2cseq_top i2cseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .eng_go    (eng_go),
    .eng_op    (eng_op),
    .wr_pop    (wr_pop),
    .rd_valid  (rd_valid),
    .done      (done),
    .result    (result)
);

// File: tb/tb_i2cseq_top.sv
module tb_i2cseq_top;
    localparam int LEN_W  = 8;
    localparam int MAXA   = 4;
    localparam int TMO    = 20;
    localparam int DLY    = 3;
    localparam int ALEN_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_read = 1'b0;
    logic [6:0]        cmd_dev = '0;
    logic [ALEN_W-1:0] cmd_alen = '0;
    logic [31:0]       cmd_regaddr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [7:0]        wr_byte;
    logic              wr_pop;
    logic [7:0]        rd_data;
    logic              rd_valid;
    logic              bus_busy = 1'b0;
    logic              eng_go;
    logic [2:0]        eng_op;
    logic [7:0]        eng_byte;
    logic              eng_last;
    logic              eng_done = 1'b0;
    logic              eng_nack = 1'b0;
    logic              eng_lost = 1'b0;
    logic [7:0]        eng_rbyte = '0;
    logic              done;
    logic [2:0]        result;

    i2cseq_top #(.LEN_W(LEN_W), .MAX_ALEN(MAXA), .TMO_CYCLES(TMO)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_read(cmd_read), .cmd_dev(cmd_dev), .cmd_alen(cmd_alen),
        .cmd_regaddr(cmd_regaddr), .cmd_len(cmd_len), .wr_byte(wr_byte),
        .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_busy(bus_busy), .eng_go(eng_go), .eng_op(eng_op),
        .eng_byte(eng_byte), .eng_last(eng_last), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_lost(eng_lost), .eng_rbyte(eng_rbyte),
        .done(done), .result(result)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural byte engine and logging
    logic       tb_clr = 1'b0;
    int         nack_pos = -1;
    int         lost_pos = -1;
    int         hang_pos = -1;
    int         log_n, bidx, cur, pend, rd_n, wr_cnt, done_cnt;
    logic       cur_rxlast;
    logic [2:0] log_op   [64];
    logic [7:0] log_byte [64];
    logic       log_last [64];
    logic [7:0] rd_buf   [64];

    assign wr_byte = 8'h50 + wr_cnt[7:0];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        eng_done <= 1'b0;
        eng_nack <= 1'b0;
        eng_lost <= 1'b0;
        if (tb_clr) begin
            log_n <= 0; bidx <= 0; cur <= 0; pend <= 0;
            rd_n <= 0; wr_cnt <= 0; done_cnt <= 0; cur_rxlast <= 1'b0;
        end else begin
            if (eng_go) begin
                log_op[log_n]   <= eng_op;
                log_byte[log_n] <= eng_byte;
                log_last[log_n] <= eng_last;
                log_n <= log_n + 1;
                if (eng_op != 3'd4) begin
                    cur <= bidx;
                    cur_rxlast <= (eng_op == 3'd3) && eng_last;
                    bidx <= bidx + 1;
                    if (bidx != hang_pos) pend <= DLY;
                end
            end
            if (pend > 0) begin
                pend <= pend - 1;
                if (pend == 1) begin
                    eng_done  <= 1'b1;
                    eng_nack  <= (cur == nack_pos) || cur_rxlast;
                    eng_lost  <= (cur == lost_pos);
                    eng_rbyte <= 8'hA0 + cur[7:0];
                end
            end
            if (rd_valid) begin
                rd_buf[rd_n] <= rd_data;
                rd_n <= rd_n + 1;
            end
            if (wr_pop) wr_cnt <= wr_cnt + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // expected log
    int         en;
    logic [2:0] e_op   [64];
    logic [7:0] e_byte [64];
    logic       e_last [64];
    logic       e_data [64];

    task automatic add(input logic [2:0] op, input logic [7:0] b, input logic l, input logic d);
        e_op[en] = op; e_byte[en] = b; e_last[en] = l; e_data[en] = d; en++;
    endtask

    // busy_mode: 0 free, 1 stuck busy, 2 busy for a while then free
    task automatic run_txn(input bit rd, input logic [6:0] dev, input int alen,
                           input logic [31:0] ra, input int len,
                           input int np, input int lp, input int hp,
                           input int busy_mode, input bit poke, input string req);
        int abort, exp_res, exp_rd, exp_wr, k, wd, bad;
        en = 0; exp_rd = 0; exp_wr = 0; exp_res = 0;
        abort = (np >= 0) ? np : (lp >= 0) ? lp : hp;
        if (len == 0 || alen > MAXA) begin
            exp_res = 1;
        end else if (busy_mode == 1) begin
            exp_res = 4;
        end else begin
            add((rd && alen == 0) ? 3'd1 : 3'd0, {dev, rd && alen == 0}, 1'b0, 1'b0);
            for (int i = 0; i < alen; i++) add(3'd2, ra[(alen-1-i)*8 +: 8], 1'b0, 1'b0);
            if (rd && alen > 0) add(3'd1, {dev, 1'b1}, 1'b0, 1'b0);
            for (int j = 0; j < len; j++) begin
                if (rd) add(3'd3, 8'h00, j == len - 1, 1'b1);
                else    add(3'd2, 8'h50 + j[7:0], 1'b0, 1'b1);
            end
            if (abort >= 0) en = abort + 1;
            for (int i = 0; i < en; i++) begin
                if (e_data[i] && e_op[i] == 3'd2) exp_wr++;
                if (e_op[i] == 3'd3 && !(i == abort && (lp >= 0 || hp >= 0))) exp_rd++;
            end
            exp_res = (np >= 0) ? 2 : (lp >= 0) ? 3 : (hp >= 0) ? 4 : 0;
            add(3'd4, 8'h00, 1'b0, 1'b0);
        end

        @(negedge clk);
        nack_pos = np; lost_pos = lp; hang_pos = hp;
        bus_busy = (busy_mode != 0);
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
        chk(cmd_ready == 1'b1, {req, " R11 ready before command"}, cmd_ready, 1);
        cmd_read = rd; cmd_dev = dev; cmd_alen = alen[ALEN_W-1:0];
        cmd_regaddr = ra; cmd_len = len[LEN_W-1:0];
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wd = 0;
        while (!done && wd < 3000) begin
            @(negedge clk);
            wd++;
            if (poke && wd == 4) begin
                cmd_valid = 1'b1; cmd_dev = ~dev; cmd_read = ~rd;
            end else begin
                cmd_valid = 1'b0;
            end
            if (busy_mode == 2 && wd == 8) begin
                chk(log_n == 0, {req, " R2 no operation while busy"}, log_n, 0);
                bus_busy = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        if (wd >= 3000) begin
            chk(1'b0, {req, " watchdog"}, wd, 0);
            finish_run();
        end
        chk(result == exp_res[2:0], {req, " result"}, result, exp_res);
        repeat (3) @(negedge clk);
        bus_busy = 1'b0;
        chk(done_cnt == 1, {req, " R10 single done"}, done_cnt, 1);
        chk(log_n == en, {req, " op count"}, log_n, en);
        bad = -1;
        for (int i = 0; i < en && i < log_n; i++) begin
            if (log_op[i] != e_op[i]) bad = i;
            else if ((e_op[i] <= 3'd2) && log_byte[i] != e_byte[i]) bad = i;
            else if (e_op[i] == 3'd3 && log_last[i] != e_last[i]) bad = i;
        end
        if (bad >= 0) chk(1'b0, {req, " op log entry"}, log_op[bad], e_op[bad]);
        else          chk(1'b1, {req, " op log"}, 0, 0);
        chk(rd_n == exp_rd, {req, " R6 read byte count"}, rd_n, exp_rd);
        k = 0;
        for (int i = 0; i < en; i++) begin
            if (e_op[i] == 3'd3 && k < rd_n && k < exp_rd) begin
                chk(rd_buf[k] == 8'hA0 + i[7:0], {req, " R6 read data"}, rd_buf[k], 8'hA0 + i);
                k++;
            end
        end
        chk(wr_cnt == exp_wr, {req, " R13 write pops"}, wr_cnt, exp_wr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
        chk(cmd_ready && !done && !eng_go && !rd_valid && !wr_pop, "reset state", cmd_ready, 1);

        // R3 R4 R5 R6 R13 sweep over direction, register-byte count and length
        for (int rd = 0; rd < 2; rd++)
            for (int a = 0; a <= MAXA; a++)
                for (int l = 1; l <= 3; l++)
                    run_txn(rd[0], 7'h2A + a[6:0], a, 32'hC1D2E3F4, l, -1, -1, -1, 0, 0, "R3 R4 R5 sweep");

        // R1 bad requests
        run_txn(1'b0, 7'h11, 2, 32'h1234, 0, -1, -1, -1, 0, 0, "R1 zero length write");
        run_txn(1'b1, 7'h11, 0, 32'h0,    0, -1, -1, -1, 0, 0, "R1 zero length read");
        run_txn(1'b0, 7'h11, 5, 32'h0,    2, -1, -1, -1, 0, 0, "R1 oversize address");

        // R2 bus busy
        run_txn(1'b0, 7'h22, 1, 32'h77, 1, -1, -1, -1, 1, 0, "R2 busy timeout");
        run_txn(1'b1, 7'h22, 1, 32'h77, 2, -1, -1, -1, 2, 0, "R2 busy then free");

        // R7 NACK at every byte of a write (dev, 2 reg, 2 data) and on read transmit phases
        for (int p = 0; p < 5; p++)
            run_txn(1'b0, 7'h33, 2, 32'hABCD, 2, p, -1, -1, 0, 0, "R7 write nack");
        for (int p = 0; p < 3; p++)
            run_txn(1'b1, 7'h34, 1, 32'h5A, 2, p, -1, -1, 0, 0, "R7 read nack");

        // R9 lost arbitration at every byte of a read with address
        for (int p = 0; p < 5; p++)
            run_txn(1'b1, 7'h44, 1, 32'h9C, 2, -1, p, -1, 0, 0, "R9 lost");

        // R8 per-byte timeout at several positions
        for (int p = 0; p < 4; p++)
            run_txn(p[0], 7'h55, 1, 32'h3E, 2, -1, -1, p, 0, 0, "R8 hang");

        // R12 probe
        run_txn(1'b1, 7'h50, 0, 32'h0, 1, -1, -1, -1, 0, 0, "R12 probe ack");
        run_txn(1'b1, 7'h51, 0, 32'h0, 1, 0, -1, -1, 0, 0, "R12 probe nack");

        // R11 command during a transaction is ignored
        run_txn(1'b0, 7'h66, 2, 32'h0102, 3, -1, -1, -1, 0, 1, "R11 poke write");
        run_txn(1'b1, 7'h67, 3, 32'h030405, 2, -1, -1, -1, 0, 1, "R11 poke read");

        finish_run();
    end

    initial begin
        wait (cycles > 190000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        finish_run();
    end
endmodule